// File: doc/BRIEF.md
# Auto-Switching Sinc Decimation Filter

This block turns a one-bit delta-sigma modulator stream into signed output words. Each input bit counts as +1 or -1. A programmable decimation ratio N sets how many bits make up one conversion. For each conversion the block produces one word from one of three responses:

- a first-order boxcar average over the last N bits, which settles quickly;
- a second-order sinc;
- a third-order sinc.

The sinc responses are built as cascaded integrators, followed by differentiators that run at the decimated rate.

In automatic mode the filter order follows a schedule after each channel or gain change. The first word after the change comes from the fast response, the second from the second-order sinc, and all later words from the third-order sinc. Early results therefore arrive quickly, and later results have low noise. A change strobe marks the channel or gain change. It clears all filter state, so no data from before the change reaches the output. Each word is scaled to a fixed output width by an arithmetic shift. A tag reports the order that produced the word.

Top module: `auto_sinc_decimator`

## Requirements
- R1: While rst_n is low at a rising edge, the block resets. After that edge dvalid is 0, dout is 0 and order_tag is 0.
- R2: A mod_bit of 1 counts as +1 and a mod_bit of 0 counts as -1. A word tagged 1 is the unscaled sum of the N samples of its own conversion. The tag encodings are: 1 = fast boxcar, 2 = second-order sinc, 3 = third-order sinc.
- R3: A word tagged k (k = 2 or 3) is the last k*N samples weighted by k convolved length-N boxcars. Samples from before the last change strobe count as zero.
- R4: The scaling uses L, the bit length of N, and s = k*L. The unscaled value is shifted left by 23-s when s <= 23, and arithmetically right by s-23 otherwise. dout is the low 24 bits of the result.
- R5: A conversion is N consecutive samples taken at rising edges with rst_n high and chg low. dvalid is high for exactly one cycle, in the cycle after the edge that takes the N-th sample.
- R6: At an edge where chg is high, the block clears all filter state and resets the conversion count. It discards that edge's sample, does not raise dvalid after it, and loads a new N from dec_ratio. A dec_ratio below 2 is taken as 2.
- R7: mode encodings are 0 = fast, 1 = second-order, 2 = third-order and 3 = automatic. With mode held at 3, the words after a change carry tags 1, 2, 3, 3, 3 and so on. The schedule counts conversions since the last change, in any mode.
- R8: The block samples mode at each conversion boundary, at reset and at change edges. A mode change in the middle of a conversion first affects the conversion that starts at the next boundary.
- R9: dec_ratio is loaded only at reset and at change edges. A new value has no effect on the conversion length until the next chg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_bit | input | 1 | Modulator bit, one sample per clock |
| dec_ratio | input | DEC_W | Decimation ratio N, loaded at reset and change |
| mode | input | 2 | Filter selection: 0 fast, 1 sinc2, 2 sinc3, 3 automatic |
| chg | input | 1 | Channel or gain change strobe |
| dout | output | OUT_W | Scaled signed output word |
| order_tag | output | 2 | Order that produced dout (1 to 3) |
| dvalid | output | 1 | One-cycle pulse marking a new word |

## Verification
The bench targets four corner cases:

- **Automatic schedule after a change.** A design that forgot to clear its differentiator delays would leak the old channel into the first words. A design with a miscounted schedule would tag them wrongly.
- **Mode change in the middle of a conversion.** Applying the new mode at once would change the order of the word already in progress.
- **Extreme ratios.** A ratio below 2 must become 2. A ratio of 600 with a third-order response needs a right shift rather than a left shift. Choosing the wrong shift would overflow or zero the word.
- **Ratio written without a change strobe.** Taking that ratio immediately would shorten or stretch the conversion period.

// File: rtl/auto_sinc_decimator.sv
module auto_sinc_decimator #(
  parameter int DEC_W = 10,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic [DEC_W-1:0] dec_ratio,
  input  logic [1:0]       mode,
  input  logic             chg,
  output logic [OUT_W-1:0] dout,
  output logic [1:0]       order_tag,
  output logic             dvalid
);
  localparam int AW  = 3*DEC_W + 2;
  localparam int TOP = OUT_W - 1;

  logic [DEC_W-1:0] n_q, cnt, n_in;
  logic [1:0]       mode_q, conv, ord;
  logic signed [AW-1:0] x, i1, i2, i3, i1n, i2n, i3n;
  logic signed [AW-1:0] c11, c21, c22, c31, c32, c33;
  logic signed [AW-1:0] y1, y2a, y2, y3a, y3b, y3, acc, sh;
  logic last;
  int   blen, s;

  assign n_in = (dec_ratio < DEC_W'(2)) ? DEC_W'(2) : dec_ratio;
  assign x    = mod_bit ? AW'(1) : -AW'(1);
  assign i1n  = i1 + x;
  assign i2n  = i2 + i1n;
  assign i3n  = i3 + i2n;
  assign y1   = i1n - c11;
  assign y2a  = i2n - c21;
  assign y2   = y2a - c22;
  assign y3a  = i3n - c31;
  assign y3b  = y3a - c32;
  assign y3   = y3b - c33;
  assign last = (cnt == n_q - DEC_W'(1));
  assign ord  = (mode_q == 2'd3) ? ((conv == 2'd3) ? 2'd3 : conv + 2'd1) : mode_q + 2'd1;
  assign acc  = (ord == 2'd1) ? y1 : (ord == 2'd2) ? y2 : y3;

  always_comb begin
    blen = 0;
    for (int b = 0; b < DEC_W; b++)
      if (n_q[b]) blen = b + 1;
    s = int'(ord) * blen;
    if (s <= TOP) sh = acc <<< (TOP - s);
    else          sh = acc >>> (s - TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || chg) begin
      n_q    <= n_in;
      mode_q <= mode;
      cnt    <= '0;
      conv   <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0;
      c11 <= '0; c21 <= '0; c22 <= '0; c31 <= '0; c32 <= '0; c33 <= '0;
      dvalid <= 1'b0;
      if (!rst_n) begin
        dout      <= '0;
        order_tag <= '0;
      end
    end else begin
      i1 <= i1n; i2 <= i2n; i3 <= i3n;
      dvalid <= last;
      if (last) begin
        cnt       <= '0;
        conv      <= (conv == 2'd3) ? 2'd3 : conv + 2'd1;
        mode_q    <= mode;
        c11 <= i1n;
        c21 <= i2n; c22 <= y2a;
        c31 <= i3n; c32 <= y3a; c33 <= y3b;
        dout      <= sh[OUT_W-1:0];
        order_tag <= ord;
      end else begin
        cnt <= cnt + DEC_W'(1);
      end
    end
  end

  logic       auto_w;
  logic [1:0] lt;
  always_ff @(posedge clk) begin
    if (!rst_n || chg) begin
      auto_w <= 1'b0;
      lt     <= '0;
    end else begin
      if (last) auto_w <= (mode_q == 2'd3);
      if (dvalid) lt <= auto_w ? order_tag : 2'd0;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dvalid |=> !dvalid); // R5
  AST_CHG_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) chg |=> !dvalid); // R6
  AST_TAG_LEGAL:   assert property (@(posedge clk) disable iff (!rst_n) dvalid |-> order_tag != 2'd0); // R2
  AST_AUTO_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                     (dvalid && auto_w && lt != 2'd0) |-> ({1'b0, order_tag} == {1'b0, lt} || {1'b0, order_tag} == {1'b0, lt} + 3'd1)); // R7
  AST_RATIO_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !chg |=> $stable(n_q)); // R9
endmodule

// File: tb/sim_auto_sinc_decimator.sv
module sim_auto_sinc_decimator;
  logic clk = 1'b0, rst_n = 1'b0, mod_bit = 1'b0, chg = 1'b0;
  logic [9:0] dec_ratio = 10'd16;
  logic [1:0] mode = 2'd3;
  logic [23:0] dout;
  logic [1:0]  order_tag;
  logic        dvalid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  auto_sinc_decimator u0 (.clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .dec_ratio(dec_ratio),
    .mode(mode), .chg(chg), .dout(dout), .order_tag(order_tag), .dvalid(dvalid));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int hist[$];
  int nm, mq, conv, cnt;
  bit e_valid; logic [23:0] e_data; int e_tag;
  string lab_v, lab_t, lab_d;

  function automatic longint filt(int k);
    longint w[], nw[], y;
    int bl;
    w = new[nm];
    foreach (w[i]) w[i] = 1;
    for (int r = 1; r < k; r++) begin
      nw = new[w.size() + nm - 1];
      foreach (nw[i]) nw[i] = 0;
      foreach (w[a]) for (int b = 0; b < nm; b++) nw[a+b] += w[a];
      w = nw;
    end
    y = 0;
    foreach (w[j]) if (hist.size() - 1 - j >= 0) y += w[j] * hist[hist.size()-1-j];
    bl = 0;
    for (int b = 0; b < 10; b++) if (nm[b]) bl = b + 1;
    if (k*bl <= 23) y = y <<< (23 - k*bl);
    else            y = y >>> (k*bl - 23);
    return y;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || chg) begin
      nm = (dec_ratio < 2) ? 2 : int'(dec_ratio);
      mq = mode; conv = 0; cnt = 0; hist.delete();
      e_valid = 0;
      if (!rst_n) begin e_data = 0; e_tag = 0; end
      lab_v = "R6";
    end else begin
      hist.push_back(mod_bit ? 1 : -1);
      while (hist.size() > 3*nm) void'(hist.pop_front());
      cnt++;
      e_valid = 0;
      lab_v = (int'(dec_ratio) != nm) ? "R9" : (conv == 0 ? "R6" : "R5");
      if (cnt == nm) begin
        cnt = 0;
        e_tag = (mq == 3) ? ((conv + 1 > 3) ? 3 : conv + 1) : mq + 1;
        lab_t = (mq == 3) ? "R7" : "R8";
        lab_d = (e_tag == 1) ? "R2" : "R3";
        e_data = 24'(filt(e_tag));
        e_valid = 1;
        conv = (conv + 1 > 3) ? 3 : conv + 1;
        mq = mode;
      end
    end
  end

  bit cmp_en = 0;
  always @(negedge clk) if (cmp_en && !done) begin
    check(lab_v, dvalid, e_valid);
    if (e_valid) begin
      check(lab_t, order_tag, e_tag);
      check(lab_d, dout, e_data);
    end
  end

  task automatic drive(int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (pat)
        0: mod_bit = 1'b1;
        1: mod_bit = 1'b0;
        2: mod_bit = 1'($urandom);
        default: mod_bit = ~mod_bit;
      endcase
    end
  endtask

  task automatic strobe();
    @(negedge clk); chg = 1'b1;
    @(negedge clk); chg = 1'b0;
  endtask

  task automatic next_word(output logic [23:0] d, output logic [1:0] t);
    @(negedge clk);
    while (!dvalid) @(negedge clk);
    d = dout; t = order_tag;
  endtask

  logic [23:0] d; logic [1:0] t;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 dvalid", dvalid, 0);
    check("R1 dout", dout, 0);
    check("R1 tag", order_tag, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    mod_bit = 1'b1;
    // auto schedule, constant ones, N=16
    next_word(d, t); check("R2 first word", d, 16 <<< 18); check("R7 tag1", t, 1);
    next_word(d, t); check("R7 tag2", t, 2);
    next_word(d, t); check("R7 tag3", t, 3);
    next_word(d, t); check("R7 tag3 hold", t, 3);
    // random stream, then change mid-conversion
    drive(100, 2);
    drive(5, 1);
    strobe();
    drive(130, 2);
    drive(64, 3);
    // manual modes, mode change mid-conversion
    mode = 2'd0; strobe();
    drive(40, 2);
    @(negedge clk); while (!dvalid) @(negedge clk);
    drive(6, 2); mode = 2'd2;
    next_word(d, t); check("R8 old mode kept", t, 1);
    next_word(d, t); check("R8 new mode", t, 3);
    mode = 2'd1; drive(60, 2);
    // ratio written without strobe
    mode = 2'd3; dec_ratio = 10'd20;
    drive(80, 2);
    strobe();
    drive(90, 2);
    // ratio below two
    dec_ratio = 10'd1; strobe();
    mod_bit = 1'b1;
    next_word(d, t); check("R6 min ratio tag", t, 1);
    check("R6 min ratio word", d, 2 <<< 21);
    drive(20, 2);
    // large ratio, right-shift scaling
    dec_ratio = 10'd600; strobe();
    mod_bit = 1'b1;
    next_word(d, t);
    next_word(d, t);
    next_word(d, t); check("R4 tag", t, 3); check("R4 sinc3 N=600", d, 1687500);
    drive(700, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule